// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block observes a two-wire I2C bus through its sampled clock (SCL) and data (SDA) lines. It keeps three status flags for the surrounding controller: an acknowledge flag, a start flag and a stop flag. It also reports a byte-phase count of SCL rising edges within the current byte. Start and stop conditions are found by comparing each new line sample with the previous one. Each flag then follows its own set of bus-phase and control events.

The block never drives the bus. It gives firmware-visible status logic a cycle-accurate view of where the bus is in a transfer. While the start flag is set, the address byte is in progress. The stop flag shows that the bus is free until the next transfer really begins. A module-enable bit, a release-from-communication pulse and a wakeup-enable bit shape the flags from the control side.

Top module: `i2c_flag_tracker`

## Requirements
- R1: A start condition (SDA sampled falling while SCL is high in both samples) sets the start flag and forces the byte-phase count to 0.
- R2: A stop condition (SDA sampled rising while SCL is high in both samples) sets the stop flag, clears the start and acknowledge flags, and forces the count to 0.
- R3: Each SCL rising edge advances the count 1, 2, … 9. A rising edge while the count is 9 or 0 (the first clock of a byte) sets it to 1. The count never exceeds 9.
- R4: At the ninth SCL rising edge of a byte, the acknowledge flag is set if SDA is low and left clear if SDA is high.
- R5: The acknowledge flag is cleared at the first SCL rising edge of the following byte.
- R6: The start flag stays set through the whole address byte. It is cleared at the first SCL rising edge of the byte that follows it.
- R7: A release pulse clears the acknowledge and start flags and leaves the stop flag unchanged.
- R8: Once set, the stop flag survives a later start condition and any SCL rising edge not preceded by such a start. It is cleared only at the first SCL rising edge after a later start.
- R9: A 1-to-0 transition of the wakeup-enable input clears the stop flag.
- R10: While the enable input is 0, or the synchronous active-low reset is asserted, all three flags and the count read 0 and bus activity is ignored.
- R11: A repeated start (a start with no stop before it) sets the start flag again and returns the count to 0 in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| enable_i | input | 1 | Module enable; 0 holds all state at zero |
| release_i | input | 1 | Release-from-communication pulse |
| wake_en_i | input | 1 | Wakeup enable; its falling transition clears the stop flag |
| ack_flag_o | output | 1 | Acknowledge detected |
| start_flag_o | output | 1 | Start condition detected (address phase) |
| stop_flag_o | output | 1 | Stop condition detected (bus free) |
| bit_count_o | output | 4 | SCL rising edges in the current byte, 0 to 9 |

## Verification
The bound checker watches the count's range and wrap order on every cycle. It also checks that the acknowledge flag only rises on the ninth clock, that a rising stop flag arrives with the start and acknowledge flags clear and a zero count, that the start flag rises together with a zero count, and that a low enable forces everything to zero on the next cycle. Some behaviours depend on the history of the transfer and are shown only by the bench's scenarios: a stop flag that outlives a bare clock edge but clears after a genuine start, a release pulse that spares the stop flag, the wakeup-enable falling edge, repeated starts, and bus activity ignored while disabled.

// File: rtl/i2c_flag_pkg.sv
// Package: shared types for the I2C status flag tracker.
// Assumes: one-bit events, each valid for a single system clock cycle.
package i2c_flag_pkg;

    // Decoded bus events for one system clock cycle.
    typedef struct packed {
        logic start;     // SDA fell while SCL stayed high
        logic stop;      // SDA rose while SCL stayed high
        logic scl_rise;  // SCL went from low to high
    } bus_evt_t;

endpackage

// File: rtl/i2c_line_sampler.sv
// Module: samples SCL and SDA through a register chain and decodes start,
// stop and SCL rising events by comparing the two oldest samples.
// Assumes: the lines are held stable for at least two system clocks per level;
// the chain resets to the idle bus level (both lines high).
module i2c_line_sampler
    import i2c_flag_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     sda_o
);

    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;
    logic            scl_now, scl_prev, sda_now, sda_prev;

    // Shift both lines into their sample chains every system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[STAGES-1:0], sda_i};
        end
    end

    assign scl_now  = scl_sh[STAGES-1];
    assign scl_prev = scl_sh[STAGES];
    assign sda_now  = sda_sh[STAGES-1];
    assign sda_prev = sda_sh[STAGES];

    // Decode the bus events from the newest and previous samples.
    always_comb begin
        evt_o.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt_o.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
        evt_o.scl_rise = scl_now & ~scl_prev;
    end

    assign sda_o = sda_now;

endmodule

// File: rtl/i2c_clk_counter.sv
// Module: counts SCL rising edges within a byte, from 1 up to LAST_CLK, and
// wraps to 1 on the first edge of the next byte.
// Assumes: start and stop events never coincide with an SCL rising event.
module i2c_clk_counter
    import i2c_flag_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LAST_CLK = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  bus_evt_t         evt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             first_o,
    output logic             last_o,
    output logic             idle_o
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_CLK);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Advance, wrap or clear the per-byte clock count.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            cnt_q <= '0;
        end else if (evt_i.start || evt_i.stop) begin
            cnt_q <= '0;
        end else if (evt_i.scl_rise) begin
            cnt_q <= (first_o) ? ONE_V : cnt_q + ONE_V;
        end
    end

    assign cnt_o   = cnt_q;
    assign idle_o  = (cnt_q == '0);
    assign first_o = idle_o || (cnt_q == LAST_V);
    assign last_o  = (cnt_q == LAST_V - ONE_V);

endmodule

// File: rtl/i2c_status_flags.sv
// Module: holds the acknowledge, start and stop flags and applies their
// individual set and clear events.
// Assumes: the count-derived inputs describe the count before the current edge.
module i2c_status_flags
    import i2c_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable_i,
    input  logic     release_i,
    input  logic     wake_en_i,
    input  bus_evt_t evt_i,
    input  logic     sda_i,
    input  logic     first_i,
    input  logic     last_i,
    input  logic     idle_i,
    output logic     ack_o,
    output logic     start_o,
    output logic     stop_o
);

    logic ack_q, start_q, stop_q, stop_armed_q, wake_q;
    logic wake_fall, first_rise;

    // Remember the wakeup-enable level to find its falling transition.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_en_i;
    end

    assign wake_fall  = wake_q & ~wake_en_i;
    assign first_rise = evt_i.scl_rise & first_i;

    // Update the three flags and the stop-clear arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            ack_q        <= 1'b0;
            start_q      <= 1'b0;
            stop_q       <= 1'b0;
            stop_armed_q <= 1'b0;
        end else if (evt_i.stop) begin
            ack_q        <= 1'b0;
            start_q      <= 1'b0;
            stop_q       <= 1'b1;
            stop_armed_q <= 1'b0;
        end else begin
            if (evt_i.start) begin
                start_q <= 1'b1;
            end else if (release_i || (evt_i.scl_rise && first_i && !idle_i)) begin
                start_q <= 1'b0;
            end

            if (release_i) begin
                ack_q <= 1'b0;
            end else if (evt_i.scl_rise && last_i) begin
                ack_q <= ~sda_i;
            end else if (first_rise) begin
                ack_q <= 1'b0;
            end

            if (wake_fall) begin
                stop_q       <= 1'b0;
                stop_armed_q <= 1'b0;
            end else if (evt_i.start && stop_q) begin
                stop_armed_q <= 1'b1;
            end else if (evt_i.scl_rise && idle_i && stop_armed_q) begin
                stop_q       <= 1'b0;
                stop_armed_q <= 1'b0;
            end
        end
    end

    assign ack_o   = ack_q;
    assign start_o = start_q;
    assign stop_o  = stop_q;

endmodule

// File: rtl/i2c_flag_tracker.sv
// Module: top level of the I2C bus status flag tracker. It samples the bus,
// counts clocks per byte and maintains the acknowledge, start and stop flags.
// Assumes: SCL and SDA levels last at least SYNC_STAGES system clocks.
module i2c_flag_tracker
    import i2c_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       enable_i,
    input  logic       release_i,
    input  logic       wake_en_i,
    output logic       ack_flag_o,
    output logic       start_flag_o,
    output logic       stop_flag_o,
    output logic [3:0] bit_count_o
);

    localparam int LAST_CLK = DATA_BITS + 1;
    localparam int CNT_W    = 4;

    bus_evt_t         evt;
    logic             sda_s;
    logic             first, last, idle;
    logic [CNT_W-1:0] cnt;

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt),
        .sda_o (sda_s)
    );

    i2c_clk_counter #(.CNT_W(CNT_W), .LAST_CLK(LAST_CLK)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .evt_i    (evt),
        .cnt_o    (cnt),
        .first_o  (first),
        .last_o   (last),
        .idle_o   (idle)
    );

    i2c_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .release_i (release_i),
        .wake_en_i (wake_en_i),
        .evt_i     (evt),
        .sda_i     (sda_s),
        .first_i   (first),
        .last_i    (last),
        .idle_i    (idle),
        .ack_o     (ack_flag_o),
        .start_o   (start_flag_o),
        .stop_o    (stop_flag_o)
    );

    assign bit_count_o = cnt;

endmodule

// File: rtl/i2c_flag_checker.sv
// Module: temporal checks on the tracker's ports, attached by bind.
// Assumes: the tracker's default byte length of nine clocks.
module i2c_flag_checker #(
    parameter int LAST_CLK = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic       ack_flag_o,
    input logic       start_flag_o,
    input logic       stop_flag_o,
    input logic [3:0] bit_count_o
);

    localparam logic [3:0] LAST_V = 4'(LAST_CLK);

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!ack_flag_o && !start_flag_o && !stop_flag_o && bit_count_o == 4'd0)); // R10

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count_o <= LAST_V); // R3

    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_count_o == 4'd1 && $past(bit_count_o) != 4'd1)
        |-> ($past(bit_count_o) == 4'd0 || $past(bit_count_o) == LAST_V)); // R3

    AST_ACK_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_flag_o) |-> bit_count_o == LAST_V); // R4

    AST_STOP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_flag_o) |-> (!start_flag_o && !ack_flag_o && bit_count_o == 4'd0)); // R2

    AST_START_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag_o) |-> bit_count_o == 4'd0); // R1

endmodule

bind i2c_flag_tracker i2c_flag_checker #(.LAST_CLK(LAST_CLK)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .ack_flag_o   (ack_flag_o),
    .start_flag_o (start_flag_o),
    .stop_flag_o  (stop_flag_o),
    .bit_count_o  (bit_count_o)
);

// File: tb/test_i2c_flag_tracker.sv
`timescale 1ns/1ps
module test_i2c_flag_tracker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1, en = 1'b0, rel = 1'b0, wk = 1'b1;
    logic       ack, st, sp;
    logic [3:0] cnt;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    i2c_flag_tracker i_i2c_flag_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda),
        .enable_i     (en),
        .release_i    (rel),
        .wake_en_i    (wk),
        .ack_flag_o   (ack),
        .start_flag_o (st),
        .stop_flag_o  (sp),
        .bit_count_o  (cnt)
    );

    // Vector: scl sda en rel wk | ack start stop | count
    localparam int NV = 47;
    localparam logic [11:0] VEC [NV] = '{
        {5'b11101, 3'b000, 4'd0},  // idle
        {5'b10101, 3'b010, 4'd0},  // R1 start
        {5'b00101, 3'b010, 4'd0},
        {5'b10101, 3'b010, 4'd1},  // R3
        {5'b00101, 3'b010, 4'd1},
        {5'b10101, 3'b010, 4'd2},
        {5'b00101, 3'b010, 4'd2},
        {5'b10101, 3'b010, 4'd3},
        {5'b00101, 3'b010, 4'd3},
        {5'b10101, 3'b010, 4'd4},
        {5'b00101, 3'b010, 4'd4},
        {5'b10101, 3'b010, 4'd5},
        {5'b00101, 3'b010, 4'd5},
        {5'b10101, 3'b010, 4'd6},
        {5'b00101, 3'b010, 4'd6},
        {5'b10101, 3'b010, 4'd7},
        {5'b00101, 3'b010, 4'd7},
        {5'b10101, 3'b010, 4'd8},  // R6 start held in address byte
        {5'b00101, 3'b010, 4'd8},
        {5'b10101, 3'b110, 4'd9},  // R4 ack on ninth clock, SDA low
        {5'b00101, 3'b110, 4'd9},
        {5'b10101, 3'b000, 4'd1},  // R5 R6 first clock of next byte
        {5'b01101, 3'b000, 4'd1},
        {5'b11101, 3'b000, 4'd2},
        {5'b01101, 3'b000, 4'd2},
        {5'b11101, 3'b000, 4'd3},
        {5'b01101, 3'b000, 4'd3},
        {5'b11101, 3'b000, 4'd4},
        {5'b01101, 3'b000, 4'd4},
        {5'b11101, 3'b000, 4'd5},
        {5'b01101, 3'b000, 4'd5},
        {5'b11101, 3'b000, 4'd6},
        {5'b01101, 3'b000, 4'd6},
        {5'b11101, 3'b000, 4'd7},
        {5'b01101, 3'b000, 4'd7},
        {5'b11101, 3'b000, 4'd8},
        {5'b01101, 3'b000, 4'd8},
        {5'b11101, 3'b000, 4'd9},  // R4 SDA high: no ack
        {5'b01101, 3'b000, 4'd9},
        {5'b00101, 3'b000, 4'd9},
        {5'b10101, 3'b000, 4'd1},  // R3 wrap
        {5'b11101, 3'b001, 4'd0},  // R2 stop
        {5'b10101, 3'b011, 4'd0},  // R8 start keeps stop
        {5'b10111, 3'b001, 4'd0},  // R7 release spares stop
        {5'b10101, 3'b001, 4'd0},
        {5'b00101, 3'b001, 4'd0},
        {5'b10101, 3'b000, 4'd1}   // R8 first clock after start clears stop
    };

    // Compare one observed value with its expectation.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Check all four outputs at once.
    task automatic chk_all(input string req, input int e_ack, input int e_st,
                           input int e_sp, input int e_cnt);
        chk(req, "ack", int'(ack), e_ack);
        chk(req, "start", int'(st), e_st);
        chk(req, "stop", int'(sp), e_sp);
        chk(req, "count", int'(cnt), e_cnt);
    endtask

    // Let the inputs settle through sampling and flag registers.
    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // Drive the bus lines and wait for the result.
    task automatic bus(input logic c, input logic d);
        scl = c;
        sda = d;
        settle();
    endtask

    // Print the summary line and end the run.
    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;
        settle();
        chk_all("R10 reset", 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            {scl, sda, en, rel, wk} = VEC[i][11:7];
            settle();
            chk_all($sformatf("vec%0d", i), int'(VEC[i][6]), int'(VEC[i][5]),
                    int'(VEC[i][4]), int'(VEC[i][3:0]));
        end

        // R7: release clears the acknowledge flag (SCL high, count 1).
        for (int b = 2; b <= 9; b++) begin
            bus(1'b0, 1'b0);
            bus(1'b1, 1'b0);
        end
        chk_all("R4 ack before release", 1, 0, 0, 9);
        rel = 1'b1;
        settle();
        rel = 1'b0;
        chk_all("R7 release clears ack", 0, 0, 0, 9);

        // R8: stop survives a bare SCL edge; R9: wakeup fall clears it.
        bus(1'b1, 1'b1);
        chk_all("R2 stop", 0, 0, 1, 0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        chk_all("R8 bare clock keeps stop", 0, 0, 1, 1);
        wk = 1'b0;
        settle();
        chk_all("R9 wake fall clears stop", 0, 0, 0, 1);
        wk = 1'b1;
        settle();

        // R11: repeated start in the middle of a byte.
        bus(1'b1, 1'b0);
        chk_all("R1 start", 0, 1, 0, 0);
        for (int b = 1; b <= 3; b++) begin
            bus(1'b0, 1'b0);
            bus(1'b1, 1'b0);
        end
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        chk_all("R11 mid byte", 0, 1, 0, 4);
        bus(1'b1, 1'b0);
        chk_all("R11 repeated start", 0, 1, 0, 0);

        // R10: disable clears everything and bus activity is ignored.
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        en = 1'b0;
        settle();
        chk_all("R10 disable", 0, 0, 0, 0);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        chk_all("R10 bus ignored", 0, 0, 0, 0);
        en = 1'b1;
        settle();
        chk_all("R10 re-enable", 0, 0, 0, 0);

        // R10: synchronous reset in the middle of an address byte.
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        chk_all("R1 before reset", 0, 1, 0, 1);
        rst_n = 1'b0;
        settle();
        chk_all("R10 reset mid transfer", 0, 0, 0, 0);
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        finish_run();
    end

endmodule